// File: doc/BRIEF.md
# Partial-Sum Aggregation Engine

This block folds partial sums of output-matrix elements into memory. Each arriving contribution carries an element index, a signed value and a flag marking it as the final contribution for that element. The engine looks the index up in an external mapping table, reads the running total held at the mapped primary address and adds the new value. A non-final total goes back to the same address unchanged. A final total first passes through an activation stage and is then stored. Some elements also carry a secondary address, and their finished value is copied there as well.

The memory port has separate read and write channels. Read data returns a fixed number of cycles after the request. The engine keeps a short in-order queue of requests in flight. While an arriving index matches an element whose update is not yet written, the engine holds the input off, so every update sees the total left by the one before it. The activation is chosen by a static mode input: a straight pass or a clamping rectifier. A counter reports how many elements have been finished.

Top module: `aggr_engine`

## Requirements
- R1: In the cycle an input is accepted (`in_valid` and `in_ready` both high), `mem_rd_en` is high with `mem_rd_addr` equal to `map_addr0`; in every other cycle `mem_rd_en` is low.
- R2: For an accepted input, exactly RD_LAT cycles after acceptance (default 2), `mem_wr_en` is high with `mem_wr_addr` equal to its primary address. For a non-final input, `mem_wr_data` is the saturated sum of the stored value and the input value.
- R3: For a final input (`in_last`=1), the written value is the saturated sum passed through the activation. With `cfg_act`=0 the sum is written as is. With `cfg_act`=1 a negative sum becomes 0, and a sum above RELU_MAX (default 1000) becomes RELU_MAX.
- R4: The sum of stored value and input saturates to the signed DW-bit range (default −32768..32767) instead of wrapping.
- R5: When a final input has `map_dual`=1, the same finished value is also written to `map_addr1` in the cycle right after the primary write. Non-final inputs never write the secondary address.
- R6: `in_ready` is low while `in_idx` equals the index of any accepted input whose write has not yet happened. Repeated contributions to one element therefore accumulate exactly, and a back-to-back repeat waits RD_LAT cycles.
- R7: In the cycle after accepting a final input with `map_dual`=1, `in_ready` is low.
- R8: `done_count` rises by exactly one with each primary write of a final input and never changes otherwise.
- R9: After reset, `in_ready` is high, both memory enables are low and `done_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_act | input | 1 | Activation mode: 0 pass, 1 clamping rectifier |
| in_valid | input | 1 | Contribution present |
| in_ready | output | 1 | Contribution can be taken this cycle |
| in_idx | input | IW | Output element index |
| in_val | input | DW | Signed partial sum |
| in_last | input | 1 | Final contribution for the element |
| map_idx | output | IW | Index presented to the mapping table |
| map_addr0 | input | AW | Primary address for `map_idx` |
| map_addr1 | input | AW | Secondary address for `map_idx` |
| map_dual | input | 1 | Element has a secondary copy |
| mem_rd_en | output | 1 | Read request |
| mem_rd_addr | output | AW | Read address |
| mem_rd_data | input | DW | Read data, valid RD_LAT cycles after the request |
| mem_wr_en | output | 1 | Write strobe |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| done_count | output | CW | Number of finished elements |

## Verification
The assertions assume the mapping table answers in the same cycle, and that the memory returns, RD_LAT cycles after a read, the value stored before any write made in that same cycle. They also assume `cfg_act` changes only while nothing is in flight. The bench's memory model captures read data before it applies the write of the same edge. The bench changes the mode only after every expected write has been observed, and drives each input half a cycle away from the clock edge, so stalls are always caused by the engine and never by the bench.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
    typedef enum logic {
        ACT_PASS = 1'b0,
        ACT_RELU = 1'b1
    } act_e;
endpackage

// File: rtl/aggr_hazard.sv
module aggr_hazard #(
    parameter int IW    = 4,
    parameter int DEPTH = 2
) (
    input  logic [IW-1:0]       probe_idx,
    input  logic [DEPTH-1:0]    slot_vld,
    input  logic [DEPTH*IW-1:0] slot_idx,
    output logic                hit
);
    logic [DEPTH-1:0] match;

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        assign match[k] = slot_vld[k] && (slot_idx[k*IW +: IW] == probe_idx);
    end

    assign hit = |match;
endmodule

// File: rtl/aggr_act.sv
module aggr_act
    import aggr_pkg::*;
#(
    parameter int                    DW       = 16,
    parameter logic signed [DW-1:0]  RELU_MAX = 16'sd1000
) (
    input  logic [DW-1:0] stored,
    input  logic [DW-1:0] addend,
    input  logic          last,
    input  act_e          mode,
    output logic [DW-1:0] result
);
    localparam logic signed [DW:0] SUM_MAX = (DW+1)'((1 << (DW-1)) - 1);
    localparam logic signed [DW:0] SUM_MIN = -SUM_MAX - (DW+1)'(1);

    logic signed [DW:0]   wide;
    logic signed [DW-1:0] clipped;

    always_comb begin
        wide = $signed({stored[DW-1], stored}) + $signed({addend[DW-1], addend});
        if (wide > SUM_MAX) begin
            clipped = SUM_MAX[DW-1:0];
        end else if (wide < SUM_MIN) begin
            clipped = SUM_MIN[DW-1:0];
        end else begin
            clipped = wide[DW-1:0];
        end
        result = clipped;
        if (last && (mode == ACT_RELU)) begin
            if (clipped < 0) begin
                result = '0;
            end else if (clipped > RELU_MAX) begin
                result = RELU_MAX;
            end
        end
    end
endmodule

// File: rtl/aggr_engine.sv
module aggr_engine
    import aggr_pkg::*;
#(
    parameter int                    IW       = 4,
    parameter int                    AW       = 6,
    parameter int                    DW       = 16,
    parameter int                    CW       = 16,
    parameter int                    RD_LAT   = 2,
    parameter logic signed [DW-1:0]  RELU_MAX = 16'sd1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_act,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [IW-1:0] in_idx,
    input  logic [DW-1:0] in_val,
    input  logic          in_last,
    output logic [IW-1:0] map_idx,
    input  logic [AW-1:0] map_addr0,
    input  logic [AW-1:0] map_addr1,
    input  logic          map_dual,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic [CW-1:0] done_count
);
    localparam int TAIL = RD_LAT - 1;

    typedef struct packed {
        logic          vld;
        logic          last;
        logic          dual;
        logic [IW-1:0] idx;
        logic [DW-1:0] val;
        logic [AW-1:0] a0;
        logic [AW-1:0] a1;
    } slot_t;

    typedef struct packed {
        slot_t [RD_LAT-1:0] pipe;
        logic               bubble;
        logic               dup_vld;
        logic [AW-1:0]      dup_addr;
        logic [DW-1:0]      dup_data;
        logic [CW-1:0]      done;
    } state_t;

    state_t st_d, st_q;

    logic [RD_LAT-1:0]    flight_vld;
    logic [RD_LAT*IW-1:0] flight_idx;
    logic                 hazard_hit;
    logic                 take;
    logic [DW-1:0]        act_out;
    slot_t                tail;

    for (genvar k = 0; k < RD_LAT; k++) begin : g_flight
        assign flight_vld[k]          = st_q.pipe[k].vld;
        assign flight_idx[k*IW +: IW] = st_q.pipe[k].idx;
    end

    aggr_hazard #(.IW(IW), .DEPTH(RD_LAT)) u_hazard (
        .probe_idx (in_idx),
        .slot_vld  (flight_vld),
        .slot_idx  (flight_idx),
        .hit       (hazard_hit)
    );

    assign tail = st_q.pipe[TAIL];

    aggr_act #(.DW(DW), .RELU_MAX(RELU_MAX)) u_act (
        .stored (mem_rd_data),
        .addend (tail.val),
        .last   (tail.last),
        .mode   (act_e'(cfg_act)),
        .result (act_out)
    );

    assign map_idx  = in_idx;
    assign in_ready = !st_q.bubble && !hazard_hit;
    assign take     = in_valid && in_ready;

    always_comb begin
        st_d = st_q;

        // in-order queue of reads awaiting their data
        st_d.pipe[0].vld  = take;
        st_d.pipe[0].last = in_last;
        st_d.pipe[0].dual = map_dual;
        st_d.pipe[0].idx  = in_idx;
        st_d.pipe[0].val  = in_val;
        st_d.pipe[0].a0   = map_addr0;
        st_d.pipe[0].a1   = map_addr1;
        for (int k = 1; k < RD_LAT; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end

        // a dual final takes the write port for two cycles
        st_d.bubble  = take && in_last && map_dual;
        st_d.dup_vld = 1'b0;

        mem_rd_en   = take;
        mem_rd_addr = map_addr0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = st_q.dup_addr;
        mem_wr_data = st_q.dup_data;

        if (tail.vld) begin
            mem_wr_en   = 1'b1;
            mem_wr_addr = tail.a0;
            mem_wr_data = act_out;
            if (tail.last) begin
                st_d.done = st_q.done + CW'(1);
            end
            st_d.dup_vld  = tail.last && tail.dual;
            st_d.dup_addr = tail.a1;
            st_d.dup_data = act_out;
        end else if (st_q.dup_vld) begin
            mem_wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_count = st_q.done;
endmodule

// File: rtl/aggr_engine_chk.sv
module aggr_engine_chk #(
    parameter int IW     = 4,
    parameter int AW     = 6,
    parameter int CW     = 16,
    parameter int RD_LAT = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [IW-1:0] in_idx,
    input logic          in_last,
    input logic          map_dual,
    input logic [AW-1:0] map_addr0,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_wr_en,
    input logic [CW-1:0] done_count
);
    logic              acc;
    logic [RD_LAT-1:0] acc_sh;
    logic [IW-1:0]     idx_sh [RD_LAT];
    logic              clash;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_sh <= '0;
            for (int k = 0; k < RD_LAT; k++) idx_sh[k] <= '0;
        end else begin
            acc_sh[0] <= acc;
            idx_sh[0] <= in_idx;
            for (int k = 1; k < RD_LAT; k++) begin
                acc_sh[k] <= acc_sh[k-1];
                idx_sh[k] <= idx_sh[k-1];
            end
        end
    end

    always_comb begin
        clash = 1'b0;
        for (int k = 0; k < RD_LAT; k++) begin
            if (acc_sh[k] && idx_sh[k] == in_idx) clash = 1'b1;
        end
    end

    p_read_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (mem_rd_en && mem_rd_addr == map_addr0));

    p_no_idle_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> !mem_rd_en);

    p_write_after_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sh[RD_LAT-1] |-> mem_wr_en);

    p_no_inflight_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !clash);

    p_dual_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_last && map_dual) |=> !in_ready);

    p_done_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done_count == $past(done_count) ||
                  done_count == $past(done_count) + CW'(1)));
endmodule

bind aggr_engine aggr_engine_chk #(.IW(IW), .AW(AW), .CW(CW), .RD_LAT(RD_LAT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_idx      (in_idx),
    .in_last     (in_last),
    .map_dual    (map_dual),
    .map_addr0   (map_addr0),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .done_count  (done_count)
);

// File: tb/sim_aggr_engine.sv
`timescale 1ns/1ps
module sim_aggr_engine;
    localparam int IW = 4, AW = 6, DW = 16, CW = 16, RD_LAT = 2;
    localparam int RMAX = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_act = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] in_idx = '0;
    logic [DW-1:0] in_val = '0;
    logic          in_last = 1'b0;
    logic [IW-1:0] map_idx;
    logic [AW-1:0] map_addr0, map_addr1;
    logic          map_dual;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [DW-1:0] mem_rd_data, mem_wr_data;
    logic [CW-1:0] done_count;

    always #10 clk = ~clk;

    // mapping: primary = index, secondary = index + 32, dual for index >= 8
    assign map_addr0 = AW'(map_idx);
    assign map_addr1 = AW'(map_idx) + AW'(32);
    assign map_dual  = map_idx[IW-1];

    aggr_engine u0 (.*);

    // memory with two-cycle read latency, read sees the value before a same-edge write
    logic [DW-1:0] mem [64];
    logic [DW-1:0] rd1, rd2;
    initial for (int i = 0; i < 64; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (mem_rd_en) rd1 <= mem[mem_rd_addr];
        rd2 <= rd1;
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end
    assign mem_rd_data = rd2;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0, checks = 0;
    int ref_mem [64];
    int finals = 0;
    typedef struct { int addr; int data; int when; string req; } exp_t;
    exp_t sb [$];

    function automatic int sat(int x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: waits for acceptance, then records the expected writes
    task automatic send(int idx, int val, bit last, string req, output int waits);
        int a0, a1, s;
        exp_t e;
        waits = 0;
        @(negedge clk);
        in_valid = 1'b1; in_idx = IW'(idx); in_val = DW'(val); in_last = last;
        #1;
        while (!in_ready) begin
            waits++;
            @(negedge clk); #1;
        end
        a0 = idx; a1 = idx + 32;
        chk(mem_rd_en && mem_rd_addr == AW'(a0), "R1 read address", int'(mem_rd_addr), a0);
        s = sat(ref_mem[a0] + val);
        if (last && cfg_act) begin
            if (s < 0) s = 0;
            else if (s > RMAX) s = RMAX;
        end
        ref_mem[a0] = s;
        e.addr = a0; e.data = s; e.when = cyc + RD_LAT; e.req = req;
        sb.push_back(e);
        if (last) finals++;
        if (last && idx >= 8) begin
            ref_mem[a1] = s;
            e.addr = a1; e.when = cyc + RD_LAT + 1; e.req = "R5 secondary copy";
            sb.push_back(e);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // monitor: compares every write against the queue
    always @(negedge clk) begin
        if (rst_n && mem_wr_en) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2 unexpected write", int'(mem_wr_addr), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(int'(mem_wr_addr) == e.addr, e.req, int'(mem_wr_addr), e.addr);
                chk($signed(mem_wr_data) == e.data, e.req, $signed(mem_wr_data), e.data);
                chk(cyc == e.when, {e.req, " timing"}, cyc, e.when);
            end
        end
    end

    task automatic drain();
        int n = 0;
        while (sb.size() != 0 && n < 50) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R2 pending writes", sb.size(), 0);
    endtask

    initial begin
        int w;
        for (int i = 0; i < 64; i++) ref_mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(in_ready, "R9 ready after reset", in_ready, 1);
        chk(!mem_rd_en && !mem_wr_en, "R9 enables idle", mem_rd_en | mem_wr_en, 0);
        chk(done_count == 0, "R9 done count", done_count, 0);

        // R2/R3: pass mode accumulation over distinct elements, then finals
        send(1, 100, 0, "R2 partial sum", w);
        send(2, -50, 0, "R2 partial sum", w);
        send(1, 23, 0, "R2 partial sum", w);
        send(2, -7, 1, "R3 pass final", w);
        send(1, 5, 1, "R3 pass final", w);
        // R6: back-to-back same element stalls for RD_LAT cycles
        send(3, 10, 0, "R6 first", w);
        send(3, 11, 0, "R6 repeat", w);
        chk(w == RD_LAT, "R6 stall cycles", w, RD_LAT);
        send(3, 12, 1, "R6 repeat final", w);
        chk(w == RD_LAT, "R6 stall cycles", w, RD_LAT);
        // R4: saturation both ways
        send(4, 30000, 0, "R4 positive", w);
        send(5, -30000, 0, "R4 negative", w);
        send(4, 30000, 0, "R4 positive clip", w);
        send(5, -30000, 0, "R4 negative clip", w);
        // R5/R7: dual element final, next input waits one cycle
        send(9, 40, 0, "R5 non-final dual", w);
        send(9, 2, 1, "R5 dual final", w);
        send(6, 1, 0, "R7 after dual", w);
        chk(w == 1, "R7 bubble after dual final", w, 1);
        drain();
        chk(done_count == CW'(finals), "R8 done count", done_count, finals);

        // R3: clamping rectifier on finals
        cfg_act = 1'b1;
        send(7, -300, 0, "R3 non-final keeps sign", w);
        send(10, 2000, 0, "R3 partial", w);
        send(7, 100, 1, "R3 negative to zero", w);
        send(10, 5, 1, "R3 clamp at max", w);
        send(11, 640, 1, "R3 in range", w);
        send(12, 1, 0, "R7 after dual", w);
        chk(w == 1, "R7 bubble after dual final", w, 1);
        send(12, -9, 1, "R3 dual negative", w);
        drain();
        chk(done_count == CW'(finals), "R8 done count", done_count, finals);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule